// File: doc/BRIEF.md
# Three-Wire Configuration Register Loader

This block loads a bank of four 6-bit control registers from a three-wire serial port: a shift clock, a data line and an active-low latch line. Driving the latch line low opens a transfer. Data is then shifted in most significant bit first, one bit on each rising shift-clock edge. When the latch line returns high, the most recent eight bits form a byte. The two low bits of that byte name the target register and the upper six bits become its contents. All three serial lines are asynchronous to the block clock, so each one passes through a synchroniser before edges are detected.

The registers drive the converter's mode logic and must not move in the middle of a conversion. A `convBusy` input marks conversions. A completed transfer that arrives while `convBusy` is high is parked and is written into its register only after the conversion ends. Defaults and reserved-bit masks are parameters. Reserved positions are always stored as zero.

Top module: `cfg_serial_port`

## Requirements
- R1: While `rstN` is low, the outputs hold their default values: chMode0=6'b000100, chMode1=6'b000100, threshCfg=6'b001000, pretrigCfg=6'b000001.
- R2: Data bits are sampled only on rising `serClk` edges that occur while `serLatN` is low. Shift-clock edges seen while `serLatN` is high do not count toward a transfer.
- R3: A rising `serLatN` edge after at least eight sampled bits writes the byte to one register a few clock cycles later. Bits [7:2] of the byte, first-sampled bit as bit 7, are the register data.
- R4: Byte bits [1:0] select the register: 00 chMode0, 01 chMode1, 10 threshCfg, 11 pretrigCfg. Only the selected register changes.
- R5: If more than eight bits are shifted before the latch rises, only the last eight bits are used.
- R6: If the latch rises after fewer than eight bits, the transfer is dropped and no register changes.
- R7: Reserved bits are stored as zero whatever value is written. These are bit 5 of chMode0, bit 5 of chMode1, and bits 5:2 of pretrigCfg.
- R8: No register changes while `convBusy` is high. A byte latched during a conversion is written once `convBusy` falls.
- R9: If a second byte is latched while an earlier one is still parked, the later byte replaces the parked one. The earlier byte is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock (asynchronous) |
| serDat | input | 1 | Serial data, MSB first |
| serLatN | input | 1 | Active-low transfer enable; its rising edge latches the byte |
| convBusy | input | 1 | High while a conversion is in progress |
| chMode0 | output | 6 | Register 0: channel 1 conversion/calibration mode |
| chMode1 | output | 6 | Register 1: channel 2 conversion/calibration mode |
| threshCfg | output | 6 | Register 2: threshold detector settings |
| pretrigCfg | output | 6 | Register 3: channel 1 pre-trigger mode |

## Verification
The bench first sends a 12-bit transfer. A design that took the first eight bits instead of the last would write threshold data into the wrong register. It then sends a 5-bit transfer immediately after earlier bytes have left ones in the shifter. A loader without a bit counter would commit that stale byte. Shift-clock pulses with the latch high come just before a 7-bit transfer, so a counter that is not cleared would reach eight and write. During a busy conversion, one write is held back and then replaced by a second write. A loader that wrote through, or that kept the first parked byte, shows the wrong register values once busy drops.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int REG_W    = 6;
  localparam int NUM_REGS = 4;
  localparam int ADDR_W   = $clog2(NUM_REGS);
  localparam int BYTE_W   = REG_W + ADDR_W;
  localparam int CNT_W    = $clog2(BYTE_W + 1);

  typedef struct packed {
    logic clearCnt;  // latch fell: new transfer
    logic shiftEn;   // take one data bit
    logic capture;   // full byte latched: park it
    logic commit;    // write parked byte to its register
  } ctlStrb_t;
endpackage

// File: rtl/cfg_port_sync.sv
module cfg_port_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic serClk,
  input  logic serDat,
  input  logic serLatN,
  output logic datSync,
  output logic latLow,
  output logic clkRise,
  output logic latRise,
  output logic latFall
);
  localparam logic [2:0] IDLE_VAL = 3'b100;  // {latN, dat, clk}

  logic [2:0] rawIn;
  logic [2:0] syncd;
  logic [2:0] prevSyncd;

  assign rawIn = {serLatN, serDat, serClk};

  for (genvar g = 0; g < 3; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {STAGES{IDLE_VAL[g]}};
      else       chain <= {chain[STAGES-2:0], rawIn[g]};
    end
    assign syncd[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSyncd <= IDLE_VAL;
    else       prevSyncd <= syncd;
  end

  assign datSync = syncd[1];
  assign latLow  = !syncd[2];
  assign clkRise = syncd[0] && !prevSyncd[0];
  assign latRise = syncd[2] && !prevSyncd[2];
  assign latFall = !syncd[2] && prevSyncd[2];
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     latLow,
  input  logic     clkRise,
  input  logic     latRise,
  input  logic     latFall,
  input  logic     convBusy,
  output ctlStrb_t strb,
  output logic     pendFlag
);
  logic [CNT_W-1:0] bitCnt;
  logic             byteFull;

  assign byteFull      = (bitCnt >= CNT_W'(BYTE_W));
  assign strb.clearCnt = latFall;
  assign strb.shiftEn  = clkRise && latLow;
  assign strb.capture  = latRise && byteFull;
  assign strb.commit   = pendFlag && !convBusy;

  // Counter saturates at one byte; longer transfers keep shifting.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strb.clearCnt) begin
      bitCnt <= strb.shiftEn ? CNT_W'(1) : '0;
    end else if (strb.shiftEn && !byteFull) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pendFlag <= 1'b0;
    else if (strb.capture) pendFlag <= 1'b1;
    else if (strb.commit)  pendFlag <= 1'b0;
  end
endmodule

// File: rtl/cfg_port_dpath.sv
module cfg_port_dpath
  import cfg_port_pkg::*;
#(
  parameter logic [NUM_REGS*REG_W-1:0] DEFAULTS  = '0,
  parameter logic [NUM_REGS*REG_W-1:0] RSV_MASKS = '0
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               datSync,
  input  ctlStrb_t                           strb,
  output logic [NUM_REGS-1:0][REG_W-1:0]     regBank
);
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] holdByte;
  logic [ADDR_W-1:0] holdAddr;
  logic [REG_W-1:0]  holdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[BYTE_W-2:0], datSync};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             holdByte <= '0;
    else if (strb.capture) holdByte <= shiftReg;
  end

  assign holdAddr = holdByte[ADDR_W-1:0];
  assign holdData = holdByte[BYTE_W-1:ADDR_W];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [REG_W-1:0] KEEP = ~RSV_MASKS[g*REG_W +: REG_W];
    localparam logic [REG_W-1:0] INIT = DEFAULTS[g*REG_W +: REG_W] & KEEP;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regBank[g] <= INIT;
      else if (strb.commit && holdAddr == ADDR_W'(g))
        regBank[g] <= holdData & KEEP;
    end
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_port_pkg::*;
#(
  parameter int                          SYNC_STAGES = 2,
  parameter logic [NUM_REGS*REG_W-1:0]   DEFAULTS    = {6'b000001, 6'b001000, 6'b000100, 6'b000100},
  parameter logic [NUM_REGS*REG_W-1:0]   RSV_MASKS   = {6'b111100, 6'b000000, 6'b100000, 6'b100000}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serClk,
  input  logic             serDat,
  input  logic             serLatN,
  input  logic             convBusy,
  output logic [REG_W-1:0] chMode0,
  output logic [REG_W-1:0] chMode1,
  output logic [REG_W-1:0] threshCfg,
  output logic [REG_W-1:0] pretrigCfg
);
  logic datSync, latLow, clkRise, latRise, latFall, pendFlag;
  ctlStrb_t strb;
  logic [NUM_REGS-1:0][REG_W-1:0] regBank;

  cfg_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serDat(serDat), .serLatN(serLatN),
    .datSync(datSync), .latLow(latLow), .clkRise(clkRise),
    .latRise(latRise), .latFall(latFall)
  );

  cfg_port_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .latLow(latLow), .clkRise(clkRise),
    .latRise(latRise), .latFall(latFall), .convBusy(convBusy),
    .strb(strb), .pendFlag(pendFlag)
  );

  cfg_port_dpath #(.DEFAULTS(DEFAULTS), .RSV_MASKS(RSV_MASKS)) u_dpath (
    .clk(clk), .rstN(rstN), .datSync(datSync), .strb(strb), .regBank(regBank)
  );

  assign chMode0    = regBank[0];
  assign chMode1    = regBank[1];
  assign threshCfg  = regBank[2];
  assign pretrigCfg = regBank[3];
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk
  import cfg_port_pkg::*;
#(
  parameter logic [NUM_REGS*REG_W-1:0] RSV_MASKS = '0
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           convBusy,
  input ctlStrb_t                       strb,
  input logic                           pendFlag,
  input logic [NUM_REGS-1:0][REG_W-1:0] regBank
);
  logic [NUM_REGS-1:0][REG_W-1:0] prevBank;
  logic [NUM_REGS-1:0]            changed;
  logic                           seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  always_ff @(posedge clk) prevBank <= regBank;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
    assign changed[g] = (regBank[g] != prevBank[g]);
  end

  // R8: nothing moves on an edge where a conversion was active
  p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(convBusy) |-> $stable(regBank));

  // R3: a register changes only after a commit strobe
  p_write_needs_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.commit) |-> $stable(regBank));

  // R4: one register at most per write
  p_single_target_r4: assert property (@(posedge clk) disable iff (!rstN || !seen)
    $onehot0(changed));

  // R7: reserved positions read zero
  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regBank & RSV_MASKS) == '0);

  // R9: a parked byte is retired once the conversion has ended
  p_pend_drains_r9: assert property (@(posedge clk) disable iff (!rstN)
    pendFlag && !convBusy && !strb.capture |=> !pendFlag);
endmodule

bind cfg_serial_port cfg_port_chk #(.RSV_MASKS(RSV_MASKS)) u_chk (
  .clk(clk), .rstN(rstN), .convBusy(convBusy), .strb(strb),
  .pendFlag(pendFlag), .regBank(regBank)
);

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serDat = 1'b0, serLatN = 1'b1, convBusy = 1'b0;
  logic [5:0] chMode0, chMode1, threshCfg, pretrigCfg;

  localparam int STEP = 4;
  localparam logic [5:0] RSV [4] = '{6'b100000, 6'b100000, 6'b000000, 6'b111100};

  logic [5:0] expReg [4];
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  cfg_serial_port u0 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serDat(serDat), .serLatN(serLatN),
    .convBusy(convBusy), .chMode0(chMode0), .chMode1(chMode1),
    .threshCfg(threshCfg), .pretrigCfg(pretrigCfg)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkOne(input string tag, input int idx, input logic [5:0] act);
    nChecks++;
    if (act !== expReg[idx]) begin
      nFails++;
      $display("FAIL %s reg%0d actual=%b expected=%b", tag, idx, act, expReg[idx]);
    end
  endtask

  task automatic checkAll(input string tag);
    checkOne(tag, 0, chMode0);
    checkOne(tag, 1, chMode1);
    checkOne(tag, 2, threshCfg);
    checkOne(tag, 3, pretrigCfg);
  endtask

  // Model of a completed byte: address in [1:0], data in [7:2], reserved cleared
  task automatic modelWrite(input logic [7:0] b);
    expReg[b[1:0]] = b[7:2] & ~RSV[b[1:0]];
  endtask

  task automatic sendBits(input logic [15:0] w, input int n);
    serLatN = 1'b0;
    waitClk(STEP);
    for (int i = n - 1; i >= 0; i--) begin
      serDat = w[i];
      waitClk(STEP);
      serClk = 1'b1;
      waitClk(STEP);
      serClk = 1'b0;
    end
    waitClk(STEP);
    serLatN = 1'b1;
    waitClk(12);
  endtask

  task automatic testReset();
    expReg[0] = 6'b000100; expReg[1] = 6'b000100;
    expReg[2] = 6'b001000; expReg[3] = 6'b000001;
    waitClk(2);
    checkAll("R1 during reset");
    rstN = 1'b1;
    waitClk(4);
    checkAll("R1 after reset");
  endtask

  task automatic testEachAddress();
    logic [7:0] bytes [4] = '{8'b010101_00, 8'b011010_01, 8'b101101_10, 8'b000010_11};
    for (int k = 0; k < 4; k++) begin
      sendBits({8'h00, bytes[k]}, 8);
      modelWrite(bytes[k]);
      checkAll("R3 R4 address decode");
    end
  endtask

  task automatic testReserved();
    sendBits(16'h00FF, 8);
    modelWrite(8'hFF);
    checkAll("R7 reserved pretrig");
    sendBits(16'h00FC, 8);
    modelWrite(8'hFC);
    checkAll("R7 reserved chMode0");
  endtask

  task automatic testOverlong();
    sendBits(16'h0AD6, 12);  // last eight bits 0xD6
    modelWrite(8'hD6);
    checkAll("R5 overlong keeps last byte");
  endtask

  task automatic testShort();
    sendBits(16'h0017, 5);
    checkAll("R6 short transfer dropped");
  endtask

  task automatic testIdleClocks();
    serDat = 1'b1;
    for (int i = 0; i < 8; i++) begin
      waitClk(STEP); serClk = 1'b1;
      waitClk(STEP); serClk = 1'b0;
    end
    waitClk(12);
    checkAll("R2 clocks with latch high");
    sendBits(16'h007F, 7);
    checkAll("R2 stray edges not counted");
  endtask

  task automatic testBusyHold();
    convBusy = 1'b1;
    waitClk(2);
    sendBits(16'h0091, 8);  // 100100_01
    waitClk(20);
    checkAll("R8 held while busy");
    convBusy = 1'b0;
    waitClk(6);
    modelWrite(8'h91);
    checkAll("R8 applied after busy");
  endtask

  task automatic testNewestWins();
    convBusy = 1'b1;
    waitClk(2);
    sendBits(16'h001C, 8);  // 000111_00 parked
    sendBits(16'h0032, 8);  // 001100_10 replaces it
    waitClk(10);
    checkAll("R9 nothing while busy");
    convBusy = 1'b0;
    waitClk(6);
    modelWrite(8'h32);
    checkAll("R9 later byte wins");
  endtask

  initial begin
    testReset();
    testEachAddress();
    testReserved();
    testOverlong();
    testShort();
    testIdleClocks();
    testBusyHold();
    testNewestWins();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    waitClk(200000);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule